// File: doc/BRIEF.md
# Up-Then-Down Decade Sequence Controller

This block runs a single counting pass over a decade counter. After reset or a start request the count sits at zero with the direction flag low. Each step tick goes to the increment side of the counter while the flag is low, so the count rises one step per tick.

When the count is nine and the flag is low, the up terminal indication goes low. The next tick then does two things in the same cycle: it loads eight into the counter and flips the direction flag high. Further ticks go to the decrement side of the counter. The count falls from eight until it reaches one.

At one, with the flag high, the block reports done and blocks all further ticks. The count then stays frozen until start is pulsed again. The block is driven by a free-running clock and a one-cycle step enable. It stands in place of a gated pulse train.

Top module: `updown_decade_seq`

## Requirements
- R1: While rst is high at a clock edge, the block returns to: count 0, dir_down 0, done 0, up_tc_n 1, dn_tc_n 1.
- R2: With dir_down 0 (0 means upward), a tick on a count below nine raises the count by exactly one on the next edge, and dir_down stays 0.
- R3: up_tc_n is 0 exactly when the count is 9 and dir_down is 0. dn_tc_n is 0 exactly when the count is 0 and dir_down is 1. In every other state both are 1.
- R4: A tick at count 9 with dir_down 0 gives count 8 and dir_down 1 on the next edge. The load value is eight, binary 1000, with only bit 3 set.
- R5: With dir_down 1 and count above one, a tick lowers the count by exactly one on the next edge.
- R6: done is 1 exactly when dir_down is 1 and the count is 1. While done is 1 and start is 0, ticks leave count and dir_down unchanged.
- R7: A start pulse makes count 0, dir_down 0 and done 0 on the next edge. This holds whatever the state and even if tick is high in the same cycle.
- R8: In a cycle with tick 0 and start 0, count and dir_down keep their values.
- R9: The count never exceeds 9. After a start, the sequence of count values seen under ticks is 0,1,...,9,8,...,1, followed by a hold at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Re-arm: restart the pass from zero |
| tick | input | 1 | One-cycle step enable |
| count | output | 4 | Current decade value |
| dir_down | output | 1 | Direction flag: 0 up, 1 down |
| up_tc_n | output | 1 | Active-low upper terminal count (9 while going up) |
| dn_tc_n | output | 1 | Active-low lower terminal count (0 while going down) |
| done | output | 1 | Pass finished, ticks blocked |

## Verification
The assertions take for granted that reset is held from time zero through at least one edge. They also take for granted that tick and start are sampled as single-cycle synchronous levels. Any pattern of those levels is legal, including start and tick high in the same cycle.

The stimulus draws tick at random with a fixed seed. It draws start rarely, so that full passes and halted stretches both occur often. A directed full pass, a simultaneous start-with-tick case and long runs of idle ticks after done are added on top of the random stream.

// File: rtl/updown_decade_pkg.sv
package updown_decade_pkg;

    localparam int unsigned CNT_W    = 4;
    localparam int unsigned TOP_VAL  = 9;
    localparam int unsigned LOAD_VAL = 8;
    localparam int unsigned STOP_VAL = 1;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef struct packed {
        logic inc;
        logic dec;
    } step_t;

    function automatic logic at_value(input logic [CNT_W-1:0] q, input int unsigned v);
        return q == CNT_W'(v);
    endfunction

endpackage

// File: rtl/updown_step_router.sv
module updown_step_router
    import updown_decade_pkg::*;
(
    input  logic  tick,
    input  logic  block,
    input  dir_e  dir,
    output step_t steps
);
    logic pass;

    always_comb begin
        pass      = tick && !block;
        steps.inc = pass && (dir == DIR_UP);
        steps.dec = pass && (dir == DIR_DOWN);
    end
endmodule

// File: rtl/updown_decade_core.sv
module updown_decade_core
    import updown_decade_pkg::*;
#(
    parameter int unsigned CW    = CNT_W,
    parameter int unsigned TOP   = TOP_VAL,
    parameter int unsigned PLOAD = LOAD_VAL
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  step_t         steps,
    input  logic          load_n,
    input  dir_e          dir,
    output logic [CW-1:0] q,
    output logic          up_tc_n,
    output logic          dn_tc_n
);
    localparam logic [CW-1:0] TOP_Q  = CW'(TOP);
    localparam logic [CW-1:0] LOAD_Q = CW'(PLOAD);
    localparam logic [CW-1:0] ONE_Q  = CW'(1);

    logic any_step;
    assign any_step = steps.inc || steps.dec;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (any_step) begin
            if (!load_n)
                q <= LOAD_Q;
            else if (steps.inc)
                q <= (q == TOP_Q) ? '0 : q + ONE_Q;
            else
                q <= (q == '0) ? TOP_Q : q - ONE_Q;
        end
    end

    always_comb begin
        up_tc_n = !((q == TOP_Q) && (dir == DIR_UP));
        dn_tc_n = !((q == '0) && (dir == DIR_DOWN));
    end

    // R9: decade range
    assert_in_range_R9: assert property (@(posedge clk) disable iff (rst)
        q <= TOP_Q);

    // R2: increment by one
    assert_inc_one_R2: assert property (@(posedge clk) disable iff (rst)
        (steps.inc && load_n && !clr && q != TOP_Q) |=> q == $past(q) + ONE_Q);

    // R4: load of eight at terminal count
    assert_load_eight_R4: assert property (@(posedge clk) disable iff (rst)
        (steps.inc && !load_n && !clr) |=> q == LOAD_Q);
endmodule

// File: rtl/updown_dir_flag.sv
module updown_dir_flag
    import updown_decade_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic step,
    input  logic load_n,
    output dir_e dir
);
    always_ff @(posedge clk) begin
        if (rst || clr)
            dir <= DIR_UP;
        else if (step && !load_n)
            dir <= (dir == DIR_UP) ? DIR_DOWN : DIR_UP;
    end

    // R4: direction flips with the load
    assert_flip_on_load_R4: assert property (@(posedge clk) disable iff (rst)
        (step && !load_n && !clr) |=> dir != $past(dir));

    // R7: re-arm forces upward
    assert_rearm_up_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> dir == DIR_UP);
endmodule

// File: rtl/updown_decade_seq.sv
module updown_decade_seq
    import updown_decade_pkg::*;
#(
    parameter int unsigned CW    = CNT_W,
    parameter int unsigned TOP   = TOP_VAL,
    parameter int unsigned PLOAD = LOAD_VAL,
    parameter int unsigned STOP  = STOP_VAL
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          tick,
    output logic [CW-1:0] count,
    output logic          dir_down,
    output logic          up_tc_n,
    output logic          dn_tc_n,
    output logic          done
);
    localparam logic [CW-1:0] STOP_Q = CW'(STOP);

    dir_e          dir;
    step_t         steps;
    logic          load_n;
    logic          halted;
    logic [CW-1:0] q;

    assign halted   = (dir == DIR_DOWN) && (q == STOP_Q);
    assign load_n   = up_tc_n && dn_tc_n;
    assign count    = q;
    assign dir_down = (dir == DIR_DOWN);
    assign done     = halted;

    updown_step_router i_router (
        .tick  (tick),
        .block (halted || start),
        .dir   (dir),
        .steps (steps)
    );

    updown_decade_core #(.CW(CW), .TOP(TOP), .PLOAD(PLOAD)) i_core (
        .clk     (clk),
        .rst     (rst),
        .clr     (start),
        .steps   (steps),
        .load_n  (load_n),
        .dir     (dir),
        .q       (q),
        .up_tc_n (up_tc_n),
        .dn_tc_n (dn_tc_n)
    );

    updown_dir_flag i_dir (
        .clk    (clk),
        .rst    (rst),
        .clr    (start),
        .step   (steps.inc || steps.dec),
        .load_n (load_n),
        .dir    (dir)
    );

    // R6: halt freezes the state
    assert_halt_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(count)));

    // R7: start re-arms from zero
    assert_start_zero_R7: assert property (@(posedge clk) disable iff (rst)
        start |=> (count == '0 && !dir_down && !done));

    // R8: idle cycles hold state
    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!tick && !start) |=> ($stable(count) && $stable(dir_down)));

    // R5: decrement by one
    assert_dec_one_R5: assert property (@(posedge clk) disable iff (rst)
        (dir_down && tick && !done && !start && count != '0) |=> count == $past(count) - CW'(1));
endmodule

// File: tb/test_updown_decade_seq.sv
`timescale 1ns/1ps
module test_updown_decade_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] count;
    logic       dir_down, up_tc_n, dn_tc_n, done;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int m_cnt = 0;
    bit m_dir = 0;
    string req_tag = "R1";

    always #4 clk = ~clk;

    updown_decade_seq i_updown_decade_seq (
        .clk(clk), .rst(rst), .start(start), .tick(tick),
        .count(count), .dir_down(dir_down), .up_tc_n(up_tc_n),
        .dn_tc_n(dn_tc_n), .done(done)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit model_halted(input int c, input bit d);
        return d && c == 1;
    endfunction

    function automatic string advance(input bit t, input bit s);
        if (s) begin m_cnt = 0; m_dir = 0; return "R7"; end
        if (!t) return "R8";
        if (model_halted(m_cnt, m_dir)) return "R6";
        if (!m_dir && m_cnt == 9) begin m_cnt = 8; m_dir = 1; return "R4"; end
        if (m_dir) begin m_cnt = m_cnt - 1; return "R5"; end
        m_cnt = m_cnt + 1;
        return "R2";
    endfunction

    task automatic compare_all(input string req);
        check(req, "count", int'(count), m_cnt);
        check(req, "dir_down", int'(dir_down), int'(m_dir));
        check("R6", "done", int'(done), int'(model_halted(m_cnt, m_dir)));
        check("R3", "up_tc_n", int'(up_tc_n), int'(!(m_cnt == 9 && !m_dir)));
        check("R3", "dn_tc_n", int'(dn_tc_n), int'(!(m_cnt == 0 && m_dir)));
        check("R9", "range", int'(count <= 4'd9), 1);
    endtask

    task automatic cycle(input bit t, input bit s);
        tick = t; start = s;
        @(posedge clk);
        req_tag = advance(t, s);
        @(negedge clk);
        compare_all(req_tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seq [18];
        int exp_seq [18];
        int n;
        void'($urandom(1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_all("R1");
        rst = 1'b0;

        // directed full pass R9
        for (int i = 0; i < 10; i++) exp_seq[i] = i;
        for (int i = 10; i < 18; i++) exp_seq[i] = 18 - i;
        n = 0;
        seq[0] = int'(count);
        n = 1;
        for (int i = 0; i < 25; i++) begin
            cycle(1'b1, 1'b0);
            if (n < 18 && int'(count) != seq[n-1]) begin seq[n] = int'(count); n++; end
        end
        check("R9", "sequence length", n, 18);
        for (int i = 0; i < 18; i++) check("R9", "sequence value", seq[i], exp_seq[i]);
        check("R6", "held at one", int'(count), 1);

        // start together with tick R7
        cycle(1'b1, 1'b1);
        check("R7", "start with tick", int'(count), 0);

        // reset mid-pass R1
        for (int i = 0; i < 5; i++) cycle(1'b1, 1'b0);
        rst = 1'b1;
        @(posedge clk);
        m_cnt = 0; m_dir = 0;
        @(negedge clk);
        compare_all("R1");
        rst = 1'b0;

        // random stream
        for (int i = 0; i < 4000; i++) begin
            bit t, s;
            t = ($urandom % 100) < 60;
            s = ($urandom % 60) == 0;
            cycle(t, s);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule